// File: doc/BRIEF.md
# Time-of-Day Counter with Hourly Chime

This block keeps the time of day for a digital clock. Seconds, minutes and hours are held as two-digit packed BCD values and move forward once for every single-cycle pulse on the one-second enable input. All logic runs on one system clock. A level input picks 12-hour or 24-hour presentation of the hours, and changing it converts the hour shown without losing any time.

Two push-button inputs let a user correct the clock. Each rising edge of the minute input steps the minutes forward by one and zeroes the seconds. Each rising edge of the hour input steps the hours forward by one. Neither adjustment carries into another field. Debouncing of these inputs is done outside the block.

When normal counting takes the time to the top of an hour, the block sends a one-cycle chime request together with the hour count in 12-hour form (1 to 12). An external sound or voice unit uses this request to announce the hour. Display scanning, segment decoding and generation of the one-second pulse are done outside the block.

Top module: `tod_clock_core`

## Requirements
- R1: `sec_bcd` is packed BCD (tens in bits 7:4, ones in bits 3:0) in the range 00..59. It advances by one on each cycle where `tick` is high, and it goes from 59 to 00 with a carry into the minutes.
- R2: `min_bcd` is packed BCD in the range 00..59. It advances on a carry from the seconds, and it goes from 59 to 00 with a carry into the hours.
- R3: With `mode_12h` low, `hr_bcd` counts 00..23 in packed BCD and goes from 23 back to 00, and `pm` stays low.
- R4: With `mode_12h` high, `hr_bcd` counts 12, 01, 02 .. 11 in packed BCD. `pm` changes each time 11 moves on to 12, so it is high from 12 noon through 11 at night.
- R5: A change of `mode_12h` converts the displayed hour on the next clock edge, with seconds and minutes unchanged. For example, 13 becomes 01 with `pm` high, and the reverse change gives 13 again.
- R6: When normal counting takes minutes and seconds to 00, `chime` is high for exactly one cycle. That cycle is the same cycle in which the outputs first show mm:ss = 00:00. In that cycle, `chime_hour` holds the new hour as a binary count from 1 to 12.
- R7: A rising edge on `set_min` adds one to the minutes, going from 59 to 00 with no carry into the hours. It clears the seconds to 00 and does not raise `chime`. Holding `set_min` high gives only one step.
- R8: A rising edge on `set_hr` adds one to the hours, going from the last hour of the day to the first. The minutes and seconds are left unchanged.
- R9: A synchronous reset (`rst` high) gives 00:00:00 with `pm` low if `mode_12h` is low, or 12:00:00 with `pm` low if `mode_12h` is high. `chime` is low during reset.
- R10: With `tick` low and no rising edge on either set input, all time outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second enable, one cycle wide |
| mode_12h | input | 1 | 1 selects 12-hour hours, 0 selects 24-hour hours |
| set_min | input | 1 | Debounced minute-adjust button, acts on its rising edge |
| set_hr | input | 1 | Debounced hour-adjust button, acts on its rising edge |
| sec_bcd | output | 8 | Seconds in packed BCD |
| min_bcd | output | 8 | Minutes in packed BCD |
| hr_bcd | output | 8 | Hours in packed BCD, in the selected mode |
| pm | output | 1 | Afternoon flag; used only in 12-hour mode |
| chime | output | 1 | One-cycle top-of-hour announcement request |
| chime_hour | output | 4 | Hour to announce as binary 1..12; holds its value between requests |

## Verification
The block has no size parameters, so the bench uses the one fixed configuration. With `tick` held high every cycle, the bench runs a complete 86,400-second day in 24-hour mode and compares every output against a model based on a seconds-of-day count. This covers every digit carry, every hour boundary and the midnight wrap. In 12-hour mode, the bench steps the hour input through a full day and runs two stretches of normal counting across the 11→12 transitions. It also covers mode changes in both directions, minute adjustment at 59, and a held minute button.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } bcd2_t;

  localparam int unsigned BIN_W    = 7;
  localparam int unsigned HALF_DAY = 12;

  localparam bcd2_t SEC_LAST = '{tens: 4'd5, ones: 4'd9};
  localparam bcd2_t MIN_LAST = '{tens: 4'd5, ones: 4'd9};
  localparam bcd2_t HR_LAST  = '{tens: 4'd2, ones: 4'd3};

  // One step of a two-digit BCD field that wraps after `last`.
  function automatic bcd2_t bcd2_step(bcd2_t cur, bcd2_t last, logic clr, logic inc);
    bcd2_t r;
    r = cur;
    if (clr) begin
      r = '0;
    end else if (inc) begin
      if (cur == last) begin
        r = '0;
      end else if (cur.ones == 4'd9) begin
        r.ones = 4'd0;
        r.tens = cur.tens + 4'd1;
      end else begin
        r.ones = cur.ones + 4'd1;
      end
    end
    return r;
  endfunction

  function automatic logic [BIN_W-1:0] bcd2_to_bin(bcd2_t v);
    return BIN_W'(v.tens) * BIN_W'(10) + BIN_W'(v.ones);
  endfunction

  function automatic bcd2_t bin_to_bcd2(logic [BIN_W-1:0] b);
    bcd2_t r;
    r.tens = 4'(b / BIN_W'(10));
    r.ones = 4'(b % BIN_W'(10));
    return r;
  endfunction

  // 0..23 to the 1..12 count shown on a 12-hour face.
  function automatic logic [3:0] hour_to_12(logic [BIN_W-1:0] h);
    logic [BIN_W-1:0] r;
    if (h == '0)                        r = BIN_W'(HALF_DAY);
    else if (h > BIN_W'(HALF_DAY))      r = h - BIN_W'(HALF_DAY);
    else                                r = h;
    return 4'(r);
  endfunction

endpackage

// File: rtl/tod_rise_detect.sv
module tod_rise_detect #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] lvl_q;

  // Tracks the input even in reset, so a button held through reset gives no step.
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/tod_time_regs.sv
module tod_time_regs
  import tod_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  min_adj,
  input  logic  hr_adj,
  output bcd2_t sec_q,
  output bcd2_t min_q,
  output bcd2_t hr24_next,
  output logic  top_of_hour
);
  bcd2_t hr24_q;
  bcd2_t sec_n, min_n;
  logic  sec_inc, sec_wrap, min_inc, min_wrap, hr_inc;

  always_comb begin
    // A minute adjust zeroes the seconds and wins over a coincident tick.
    sec_inc     = tick & ~min_adj;
    sec_wrap    = sec_inc & (sec_q == SEC_LAST);
    min_inc     = min_adj | sec_wrap;
    min_wrap    = sec_wrap & (min_q == MIN_LAST);
    top_of_hour = min_wrap;
    hr_inc      = hr_adj | min_wrap;
    sec_n       = bcd2_step(sec_q,  SEC_LAST, min_adj, sec_inc);
    min_n       = bcd2_step(min_q,  MIN_LAST, 1'b0,    min_inc);
    hr24_next   = bcd2_step(hr24_q, HR_LAST,  1'b0,    hr_inc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      min_q  <= '0;
      hr24_q <= '0;
    end else begin
      sec_q  <= sec_n;
      min_q  <= min_n;
      hr24_q <= hr24_next;
    end
  end
endmodule

// File: rtl/tod_hour_view.sv
module tod_hour_view
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_12h,
  input  bcd2_t      hr24_next,
  input  logic       fire,
  output logic [7:0] hr_bcd,
  output logic       pm,
  output logic       chime,
  output logic [3:0] chime_hour
);
  logic [BIN_W-1:0] hr_bin;
  logic [3:0]       hr_12;

  always_comb begin
    hr_bin = bcd2_to_bin(hr24_next);
    hr_12  = hour_to_12(hr_bin);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_bcd     <= mode_12h ? 8'h12 : 8'h00;
      pm         <= 1'b0;
      chime      <= 1'b0;
      chime_hour <= '0;
    end else begin
      hr_bcd <= mode_12h ? bin_to_bcd2(BIN_W'(hr_12)) : hr24_next;
      pm     <= mode_12h & (hr_bin >= BIN_W'(HALF_DAY));
      chime  <= fire;
      if (fire) chime_hour <= hr_12;
    end
  end
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       mode_12h,
  input  logic       set_min,
  input  logic       set_hr,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hr_bcd,
  output logic       pm,
  output logic       chime,
  output logic [3:0] chime_hour
);
  logic [1:0] rise;
  bcd2_t      sec_q, min_q, hr24_next;
  logic       top_of_hour;

  tod_rise_detect #(.WIDTH(2)) u_rise (
    .clk  (clk),
    .lvl  ({set_hr, set_min}),
    .rise (rise)
  );

  tod_time_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .min_adj     (rise[0]),
    .hr_adj      (rise[1]),
    .sec_q       (sec_q),
    .min_q       (min_q),
    .hr24_next   (hr24_next),
    .top_of_hour (top_of_hour)
  );

  tod_hour_view u_view (
    .clk        (clk),
    .rst        (rst),
    .mode_12h   (mode_12h),
    .hr24_next  (hr24_next),
    .fire       (top_of_hour),
    .hr_bcd     (hr_bcd),
    .pm         (pm),
    .chime      (chime),
    .chime_hour (chime_hour)
  );

  assign sec_bcd = sec_q;
  assign min_bcd = min_q;
endmodule

module tod_clock_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       mode_12h,
  input logic       set_min,
  input logic       set_hr,
  input logic [7:0] sec_bcd,
  input logic [7:0] min_bcd,
  input logic [7:0] hr_bcd,
  input logic       pm,
  input logic       chime,
  input logic [3:0] chime_hour
);
  a_r1_sec_range: assert property (@(posedge clk) disable iff (rst)
    sec_bcd[7:4] <= 4'd5 && sec_bcd[3:0] <= 4'd9);

  a_r2_min_range: assert property (@(posedge clk) disable iff (rst)
    min_bcd[7:4] <= 4'd5 && min_bcd[3:0] <= 4'd9);

  a_r3_hours_24: assert property (@(posedge clk) disable iff (rst)
    (!mode_12h && $past(!mode_12h)) |->
      (!pm && hr_bcd <= 8'h23 && hr_bcd[3:0] <= 4'd9));

  a_r4_hours_12: assert property (@(posedge clk) disable iff (rst)
    (mode_12h && $past(mode_12h)) |->
      (hr_bcd == 8'h10 || hr_bcd == 8'h11 || hr_bcd == 8'h12 ||
       (hr_bcd[7:4] == 4'd0 && hr_bcd[3:0] >= 4'd1 && hr_bcd[3:0] <= 4'd9)));

  a_r6_chime_single: assert property (@(posedge clk) disable iff (rst)
    chime |=> !chime);

  a_r6_chime_at_top: assert property (@(posedge clk) disable iff (rst)
    chime |-> (sec_bcd == 8'h00 && min_bcd == 8'h00 &&
               chime_hour >= 4'd1 && chime_hour <= 4'd12));

  a_r7_min_set_clears: assert property (@(posedge clk) disable iff (rst)
    $rose(set_min) |=> (sec_bcd == 8'h00 && !chime));

  a_r8_hr_set_keeps: assert property (@(posedge clk) disable iff (rst)
    ($rose(set_hr) && !$rose(set_min) && !tick) |=>
      ($stable(min_bcd) && $stable(sec_bcd)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !$rose(set_min) && !$rose(set_hr)) |=>
      ($stable(sec_bcd) && $stable(min_bcd)));
endmodule

bind tod_clock_core tod_clock_core_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .mode_12h(mode_12h),
  .set_min(set_min), .set_hr(set_hr), .sec_bcd(sec_bcd),
  .min_bcd(min_bcd), .hr_bcd(hr_bcd), .pm(pm), .chime(chime),
  .chime_hour(chime_hour)
);

// File: tb/tb_tod_clock_core.sv
module tb_tod_clock_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode_12h = 1'b0;
  logic       set_min = 1'b0;
  logic       set_hr = 1'b0;
  logic [7:0] sec_bcd, min_bcd, hr_bcd;
  logic       pm, chime;
  logic [3:0] chime_hour;

  int checks = 0;
  int errors = 0;
  int tsec   = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tod_clock_core dut (
    .clk(clk), .rst(rst), .tick(tick), .mode_12h(mode_12h),
    .set_min(set_min), .set_hr(set_hr), .sec_bcd(sec_bcd),
    .min_bcd(min_bcd), .hr_bcd(hr_bcd), .pm(pm), .chime(chime),
    .chime_hour(chime_hour)
  );

  function automatic logic [7:0] to_bcd(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int h12(int h);
    return (h % 12 == 0) ? 12 : h % 12;
  endfunction

  task automatic cmp(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", tag, act, exp, tsec);
    end
  endtask

  task automatic check_all(input bit exp_chime, input string ctx);
    int h, m, s;
    h = tsec / 3600;
    m = (tsec / 60) % 60;
    s = tsec % 60;
    cmp(sec_bcd, to_bcd(s), {ctx, " R1 seconds"});
    cmp(min_bcd, to_bcd(m), {ctx, " R2 minutes"});
    if (mode_12h) begin
      cmp(hr_bcd, to_bcd(h12(h)), {ctx, " R4 hours"});
      cmp(pm, int'(h >= 12), {ctx, " R4 pm"});
    end else begin
      cmp(hr_bcd, to_bcd(h), {ctx, " R3 hours"});
      cmp(pm, 0, {ctx, " R3 pm"});
    end
    cmp(chime, exp_chime, {ctx, " R6 chime"});
    if (exp_chime) cmp(chime_hour, h12(h), {ctx, " R6 chime_hour"});
  endtask

  task automatic run_ticks(input int n, input string ctx);
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tsec = (tsec + 1) % 86400;
      check_all(tsec % 3600 == 0, ctx);
    end
    tick = 1'b0;
  endtask

  task automatic press_min(input string ctx);
    int h, m;
    @(negedge clk);
    set_min = 1'b1;
    @(negedge clk);
    h = tsec / 3600;
    m = (tsec / 60) % 60;
    tsec = h * 3600 + ((m + 1) % 60) * 60;
    check_all(1'b0, ctx);
    set_min = 1'b0;
    @(negedge clk);
    check_all(1'b0, ctx);
  endtask

  task automatic press_hr(input string ctx);
    int h;
    @(negedge clk);
    set_hr = 1'b1;
    @(negedge clk);
    h = tsec / 3600;
    tsec = ((h + 1) % 24) * 3600 + (tsec % 3600);
    check_all(1'b0, ctx);
    set_hr = 1'b0;
    @(negedge clk);
    check_all(1'b0, ctx);
  endtask

  task automatic hr_to(input int target, input string ctx);
    while (tsec / 3600 != target) press_hr(ctx);
  endtask

  task automatic min_to(input int target, input string ctx);
    while ((tsec / 60) % 60 != target) press_min(ctx);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R9: reset values in both modes
    repeat (3) @(negedge clk);
    tsec = 0;
    check_all(1'b0, "R9 reset 24h");
    mode_12h = 1'b1;
    @(negedge clk);
    check_all(1'b0, "R9 reset 12h");
    mode_12h = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all(1'b0, "R9 after release");

    // R10: idle cycles hold
    repeat (5) begin
      @(negedge clk);
      check_all(1'b0, "R10 idle");
    end

    // R1 R2 R3 R6: one full day in 24-hour mode
    run_ticks(86400, "day24");

    // R8: hour presses in 24-hour mode up to 13
    hr_to(13, "R8 24h");

    // R5: convert in both directions
    @(negedge clk);
    mode_12h = 1'b1;
    @(negedge clk);
    check_all(1'b0, "R5 to 12h");
    cmp(hr_bcd, 8'h01, "R5 13 shows 01");
    cmp(pm, 1, "R5 pm set");
    mode_12h = 1'b0;
    @(negedge clk);
    check_all(1'b0, "R5 to 24h");
    cmp(hr_bcd, 8'h13, "R5 back to 13");
    mode_12h = 1'b1;
    @(negedge clk);
    check_all(1'b0, "R5 to 12h again");

    // R8 R4: a full day of hour presses in 12-hour mode
    for (int i = 0; i < 24; i++) press_hr("R8 12h");

    // R4 R6: count across 11 to 12 noon and 11 to 12 midnight
    hr_to(10, "R8 setup");
    run_ticks(7200, "R4 noon");
    hr_to(23, "R8 setup");
    run_ticks(3700, "R4 midnight");

    // R7: minute wrap without carry, no chime
    min_to(59, "R7 setup");
    press_min("R7 wrap");
    cmp(min_bcd, 8'h00, "R7 minutes wrapped");

    // R7: a held button gives one step only
    @(negedge clk);
    set_min = 1'b1;
    @(negedge clk);
    tsec = (tsec / 3600) * 3600 + (((tsec / 60) % 60 + 1) % 60) * 60;
    repeat (5) begin
      @(negedge clk);
      check_all(1'b0, "R7 held");
    end
    set_min = 1'b0;
    @(negedge clk);
    check_all(1'b0, "R7 release");

    done = 1'b1;
    finish_run();
  end
endmodule